// File: doc/BRIEF.md
# Masked Error Aggregator With Reset Domains

This block gathers error indications into one fatal and one non-fatal summary line. Hardware error events are captured into sticky status bits. Firmware can also deposit an error code for each severity. A vector of external, already-aggregated error inputs is combined as well. Each of these three contributors has its own per-bit mask for each severity. The two summary outputs are driven through a fixed three-stage register pipeline.

The captured state sits in the power-good (cold) reset domain. A warm reset therefore leaves every sticky bit and firmware code untouched. A cold reset clears them all. While warm reset is asserted, the output pipeline is held in reset and both summary lines are forced low. Software uses a single write port for two jobs: clearing sticky bits by writing ones, and loading the firmware codes.

Top module: `err_collector`

## Requirements
- R1: A hardware event bit that is high on a clock edge while warm reset is released sets the matching sticky status bit, and the bit is visible right after that edge. Index 0 is the fatal set and index 1 the non-fatal set; they are driven by `hw_fatal_evt` and `hw_nonfatal_evt`.
- R2: A write with `wr_sel` = 0 or 1 clears the fatal or non-fatal sticky bits at the positions where `wr_data` holds a one. An event on the same bit in the same cycle wins over the clear. A write with `wr_sel` = 2 or 3 replaces the fatal or non-fatal firmware code with the low `CODE_W` bits of `wr_data`.
- R3: While `pwr_good` is low, both sticky registers and both firmware codes read zero, with no clock edge needed.
- R4: While `warm_rst_n` is low and `pwr_good` is high, the sticky registers and firmware codes hold their values. Events and writes are ignored during this time.
- R5: Both summary outputs are low whenever `warm_rst_n` is low.
- R6: A sticky bit whose hardware mask bit is set does not raise its summary output. An unmasked sticky bit raises it three cycles after the bit is captured.
- R7: The firmware code contributes when it has a set bit whose firmware mask bit is clear. With every mask bit set, a nonzero code does not raise the output.
- R8: Any bit of `agg_*_in & ~agg_*_mask` that is high on a clock edge raises the matching summary output three cycles later.
- R9: The fatal and non-fatal paths are independent: stimulus on one never raises the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low |
| hw_fatal_evt | input | N_HW | Fatal hardware event pulses |
| hw_nonfatal_evt | input | N_HW | Non-fatal hardware event pulses |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0/1 clear fatal/non-fatal sticky, 2/3 load fatal/non-fatal code |
| wr_data | input | DATA_W | Write data |
| hw_fatal_mask | input | N_HW | Fatal sticky masks |
| hw_nonfatal_mask | input | N_HW | Non-fatal sticky masks |
| fw_fatal_mask | input | CODE_W | Fatal firmware code masks |
| fw_nonfatal_mask | input | CODE_W | Non-fatal firmware code masks |
| agg_fatal_in | input | N_AGG | External fatal inputs |
| agg_fatal_mask | input | N_AGG | External fatal masks |
| agg_nonfatal_in | input | N_AGG | External non-fatal inputs |
| agg_nonfatal_mask | input | N_AGG | External non-fatal masks |
| hw_fatal_sts | output | N_HW | Fatal sticky status |
| hw_nonfatal_sts | output | N_HW | Non-fatal sticky status |
| fw_fatal_code | output | CODE_W | Fatal firmware code |
| fw_nonfatal_code | output | CODE_W | Non-fatal firmware code |
| all_fatal | output | 1 | Fatal summary |
| all_nonfatal | output | 1 | Non-fatal summary |

## Verification
Sticky bits and firmware codes are due one edge after the event or write. A summary output is due three edges after its combined input is sampled. A hardware event or firmware write therefore reaches the summary four edges after it is applied. The bench holds each stimulus steady over the whole latency window before it samples one time unit after an edge, so the result never depends on ordering at the edge. Masked cases are watched on every cycle of a five-cycle window. Warm-reset forcing and the cold clear are checked right after the reset pin moves, without waiting for a clock edge.

// File: rtl/err_collector.sv
module err_collector #(
  parameter int N_HW   = 8,
  parameter int CODE_W = 16,
  parameter int N_AGG  = 16
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              warm_rst_n,
  input  logic [N_HW-1:0]   hw_fatal_evt,
  input  logic [N_HW-1:0]   hw_nonfatal_evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [((N_HW > CODE_W) ? N_HW : CODE_W)-1:0] wr_data,
  input  logic [N_HW-1:0]   hw_fatal_mask,
  input  logic [N_HW-1:0]   hw_nonfatal_mask,
  input  logic [CODE_W-1:0] fw_fatal_mask,
  input  logic [CODE_W-1:0] fw_nonfatal_mask,
  input  logic [N_AGG-1:0]  agg_fatal_in,
  input  logic [N_AGG-1:0]  agg_fatal_mask,
  input  logic [N_AGG-1:0]  agg_nonfatal_in,
  input  logic [N_AGG-1:0]  agg_nonfatal_mask,
  output logic [N_HW-1:0]   hw_fatal_sts,
  output logic [N_HW-1:0]   hw_nonfatal_sts,
  output logic [CODE_W-1:0] fw_fatal_code,
  output logic [CODE_W-1:0] fw_nonfatal_code,
  output logic              all_fatal,
  output logic              all_nonfatal
);
  localparam int STAGES = 3;

  logic [N_HW-1:0]   evt   [2];
  logic [N_HW-1:0]   hmask [2];
  logic [CODE_W-1:0] fmask [2];
  logic [N_AGG-1:0]  ain   [2];
  logic [N_AGG-1:0]  amask [2];
  logic [N_HW-1:0]   sts_q [2];
  logic [CODE_W-1:0] code_q[2];
  logic [STAGES-1:0] pipe_q[2];
  logic              raw   [2];
  logic              sum   [2];
  logic              pipe_rst_n;

  assign evt[0]   = hw_fatal_evt;     assign evt[1]   = hw_nonfatal_evt;
  assign hmask[0] = hw_fatal_mask;    assign hmask[1] = hw_nonfatal_mask;
  assign fmask[0] = fw_fatal_mask;    assign fmask[1] = fw_nonfatal_mask;
  assign ain[0]   = agg_fatal_in;     assign ain[1]   = agg_nonfatal_in;
  assign amask[0] = agg_fatal_mask;   assign amask[1] = agg_nonfatal_mask;

  assign pipe_rst_n = pwr_good & warm_rst_n;

  for (genvar s = 0; s < 2; s++) begin : g_sev
    logic [N_HW-1:0] clr;
    assign clr = (wr_en && wr_sel == 2'(s)) ? wr_data[N_HW-1:0] : '0;

    always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
        sts_q[s]  <= '0;
        code_q[s] <= '0;
      end else if (warm_rst_n) begin
        sts_q[s] <= (sts_q[s] & ~clr) | evt[s];
        if (wr_en && wr_sel == 2'(s + 2)) code_q[s] <= wr_data[CODE_W-1:0];
      end
    end

    assign raw[s] = (|(sts_q[s] & ~hmask[s])) | (|(code_q[s] & ~fmask[s])) |
                    (|(ain[s] & ~amask[s]));

    always_ff @(posedge clk or negedge pipe_rst_n) begin
      if (!pipe_rst_n) pipe_q[s] <= '0;
      else             pipe_q[s] <= {pipe_q[s][STAGES-2:0], raw[s]};
    end

    assign sum[s] = pipe_q[s][STAGES-1] & warm_rst_n;

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      (warm_rst_n && evt[s] != '0) |=> ((sts_q[s] & $past(evt[s])) == $past(evt[s])));
    // R3
    cold_clear_chk: assert property (@(posedge clk)
      !pwr_good |-> (sts_q[s] == '0 && code_q[s] == '0));
    // R4
    warm_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      !warm_rst_n |=> ($stable(sts_q[s]) && $stable(code_q[s])));
    // R5
    warm_low_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      !warm_rst_n |-> !sum[s]);
    // R8
    agg_latency_chk: assert property (@(posedge clk) disable iff (!pwr_good || !warm_rst_n)
      ((ain[s] & ~amask[s]) != '0) |=> ##2 sum[s]);
  end

  assign hw_fatal_sts     = sts_q[0];
  assign hw_nonfatal_sts  = sts_q[1];
  assign fw_fatal_code    = code_q[0];
  assign fw_nonfatal_code = code_q[1];
  assign all_fatal        = sum[0];
  assign all_nonfatal     = sum[1];
endmodule

// File: tb/tb_err_collector.sv
module tb_err_collector;
  localparam int NH = 4, CW = 4, NA = 4;

  logic clk = 0, pwr_good = 1, warm_rst_n = 0;
  logic [NH-1:0] fev = 0, nev = 0, fhm = 0, nhm = 0;
  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [CW-1:0] wr_data = 0;
  logic [CW-1:0] ffm = 0, nfm = 0;
  logic [NA-1:0] fai = 0, fam = 0, nai = 0, nam = 0;
  logic [NH-1:0] fsts, nsts; logic [CW-1:0] fcode, ncode;
  logic all_f, all_n;
  int vectors = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  err_collector #(.N_HW(NH), .CODE_W(CW), .N_AGG(NA)) dut (
    .clk(clk), .pwr_good(pwr_good), .warm_rst_n(warm_rst_n),
    .hw_fatal_evt(fev), .hw_nonfatal_evt(nev),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hw_fatal_mask(fhm), .hw_nonfatal_mask(nhm),
    .fw_fatal_mask(ffm), .fw_nonfatal_mask(nfm),
    .agg_fatal_in(fai), .agg_fatal_mask(fam),
    .agg_nonfatal_in(nai), .agg_nonfatal_mask(nam),
    .hw_fatal_sts(fsts), .hw_nonfatal_sts(nsts),
    .fw_fatal_code(fcode), .fw_nonfatal_code(ncode),
    .all_fatal(all_f), .all_nonfatal(all_n));

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [CW-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic chk_outs(string tag, logic ef, logic en);
    chk({tag, " fatal"}, {31'b0, all_f}, {31'b0, ef});
    chk({tag, " nonfatal"}, {31'b0, all_n}, {31'b0, en});
  endtask

  initial begin
    #1 pwr_good = 0;
    tick(3);
    chk("R3 reset fsts", {28'b0, fsts}, 0); chk("R3 reset nsts", {28'b0, nsts}, 0);
    chk("R3 reset fcode", {28'b0, fcode}, 0); chk("R3 reset ncode", {28'b0, ncode}, 0);
    chk_outs("R5 reset", 0, 0);
    pwr_good = 1; warm_rst_n = 1; tick(4);
    chk_outs("R9 idle", 0, 0);

    // R8 / R9: exhaustive external input x mask sweep per severity
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++)
        for (int m = 0; m < 16; m++) begin
          if (s == 0) begin fai = i[3:0]; fam = m[3:0]; nai = 0; nam = 0; end
          else        begin nai = i[3:0]; nam = m[3:0]; fai = 0; fam = 0; end
          tick(3);
          chk_outs("R8 R9 agg", (s == 0) && ((i & ~m) != 0), (s == 1) && ((i & ~m) != 0));
        end
    fai = 0; nai = 0; fam = 0; nam = 0; tick(3);

    // R1 / R6 / R2: per-bit sticky capture, masking, clear
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < NH; b++) begin
        if (s == 0) fhm = 4'(1 << b); else nhm = 4'(1 << b);
        if (s == 0) fev = 4'(1 << b); else nev = 4'(1 << b);
        tick(); fev = 0; nev = 0;
        chk("R1 capture", {28'b0, (s == 0) ? fsts : nsts}, 32'(1 << b));
        chk("R9 other sts", {28'b0, (s == 0) ? nsts : fsts}, 0);
        for (int k = 0; k < 5; k++) begin tick(); chk_outs("R6 masked", 0, 0); end
        fhm = 0; nhm = 0; tick(3);
        chk_outs("R6 unmasked", s == 0, s == 1);
        wr(2'(s), 4'(1 << b));
        chk("R2 w1c", {28'b0, (s == 0) ? fsts : nsts}, 0);
        tick(3); chk_outs("R6 cleared", 0, 0);
      end
    fhm = 4'hF; nhm = 4'hF;
    fev = 4'b0011; tick(); fev = 0;
    wr(2'd0, 4'b0001);
    chk("R2 partial clear", {28'b0, fsts}, 2);
    fev = 4'b0010; wr_en = 1; wr_sel = 0; wr_data = 4'b0010; tick();
    fev = 0; wr_en = 0; wr_data = 0;
    chk("R2 event beats clear", {28'b0, fsts}, 2);
    wr(2'd0, 4'hF); chk("R2 clear all", {28'b0, fsts}, 0);
    fhm = 0; nhm = 0; tick(3);

    // R7: firmware code x mask sweep
    for (int s = 0; s < 2; s++)
      for (int c = 1; c < 16; c++)
        for (int j = 0; j < 4; j++) begin
          logic [3:0] m;
          m = (j == 0) ? 4'h0 : (j == 1) ? 4'(c) : (j == 2) ? 4'(~c) : 4'hF;
          if (s == 0) ffm = m; else nfm = m;
          wr(2'(s + 2), 4'(c));
          chk("R2 code load", {28'b0, (s == 0) ? fcode : ncode}, 32'(c));
          tick(3);
          chk_outs("R7 fw mask", (s == 0) && ((c & ~m) != 0), (s == 1) && ((c & ~m) != 0));
          wr(2'(s + 2), 4'h0); tick(3);
        end
    ffm = 0; nfm = 0; tick(3);

    // R4 / R5: warm reset keeps state, blocks updates, forces outputs low
    fev = 4'b0100; nev = 4'b0010; tick(); fev = 0; nev = 0;
    wr(2'd2, 4'h5); wr(2'd3, 4'h9); tick(4);
    chk_outs("R6 before warm", 1, 1);
    warm_rst_n = 0; #1;
    chk_outs("R5 warm immediate", 0, 0);
    fev = 4'hF; nev = 4'hF; wr_en = 1; wr_sel = 0; wr_data = 4'hF;
    for (int k = 0; k < 6; k++) begin
      wr_sel = 2'(k % 4);
      tick();
      chk("R4 hold fsts", {28'b0, fsts}, 4); chk("R4 hold nsts", {28'b0, nsts}, 2);
      chk("R4 hold fcode", {28'b0, fcode}, 5); chk("R4 hold ncode", {28'b0, ncode}, 9);
      chk_outs("R5 warm", 0, 0);
    end
    fev = 0; nev = 0; wr_en = 0; wr_data = 0; #1;
    warm_rst_n = 1; tick(3);
    chk_outs("R4 after warm", 1, 1);

    // R3: cold reset clears everything asynchronously
    #1 pwr_good = 0; #1;
    chk("R3 cold fsts", {28'b0, fsts}, 0); chk("R3 cold nsts", {28'b0, nsts}, 0);
    chk("R3 cold fcode", {28'b0, fcode}, 0); chk("R3 cold ncode", {28'b0, ncode}, 0);
    chk_outs("R5 cold", 0, 0);
    tick(); pwr_good = 1; tick(4);
    chk_outs("R3 after cold", 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule